// File: doc/BRIEF.md
# Twin Prescaled Interval Timers

This block holds two free-running interval timers that share a single control register and a single master-clock prescaler. The first timer takes a 10-bit start value and the second an 8-bit start value. Each counts up from its start value on its own tick. When the count passes its top, the timer emits a one-cycle overflow strobe, takes its start value again and keeps running. A small register write port programs the start values and the control bits. Each timer also has a sticky status flag, which is set on overflow only while that timer's enable bit is on.

The counter restarts from its start value in two cases only: when it overflows, and when its load bit goes from 0 to 1. If software writes a new start value, rewrites the load bit as 1, or changes the enable or reset bits, the count in progress is left alone. A new start value is therefore used only at the next reload. The two halves of the first timer's start value are latched separately, so the order in which software writes them does not matter.

Top module: `twin_timer`

## Requirements
- R1: With start value NA, consecutive `ovf_a` strobes are PRESCALE·(1024−NA) clocks apart. NA[9:2] is written with `wr_sel`=0 from `wr_data[7:0]`, and NA[1:0] with `wr_sel`=1 from `wr_data[1:0]`.
- R2: With start value NB, written with `wr_sel`=2, consecutive `ovf_b` strobes are PRESCALE·B_SUBDIV·(256−NB) clocks apart.
- R3: Each overflow strobe is high for exactly one clock, and a running timer keeps overflowing at a steady period.
- R4: The control register is written with `wr_sel`=3. Bit 0 is the load bit of timer A and bit 1 the load bit of timer B. A 0-to-1 change of a load bit restarts that count from the programmed start value, and the count does not resume from where it stopped. The first strobe then arrives between (N−1)·P+1 and N·P clocks after the write, where N is the tick count and P the clocks per tick. While a load bit is 0, that timer gives no strobe.
- R5: A control write that leaves a load bit at 1, or that changes only the enable or reset bits, does not move that timer's next overflow.
- R6: A write to a start value register changes nothing until the next reload. The two halves of NA are latched independently, in either order.
- R7: Bit 2 enables the flag of timer A and bit 3 the flag of timer B. A flag goes high one clock after an overflow strobe if its enable bit is set at that strobe. Otherwise the flag stays low.
- R8: A control write with bit 4 (timer A) or bit 5 (timer B) set clears that flag on the next clock. The reset bit is not stored, so the flag sets again at the next enabled overflow. An overflow in the same cycle as the clear wins over the clear.
- R9: Synchronous reset clears both flags, stops both timers and zeroes both start values. No strobe appears until a load bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 NA high, 1 NA low, 2 NB, 3 control |
| wr_data | input | 8 | Write data |
| ovf_a | output | 1 | One-cycle overflow strobe of timer A |
| ovf_b | output | 1 | One-cycle overflow strobe of timer B |
| flag_a | output | 1 | Sticky overflow flag of timer A |
| flag_b | output | 1 | Sticky overflow flag of timer B |

## Verification
The hardest case to bring about is a reload that must not happen. It has to be shown that rewriting the load bit, the enable or reset bits, or a start-value half in the middle of a period leaves the overflow timing unchanged. The stimulus therefore times its writes from an observed strobe and lands them well inside the period. It then measures the full strobe-to-strobe interval across the write, and again over the following period, to see when the new start value actually takes hold. The restart case stops a timer about halfway through a period and starts it again. The time to the next strobe must then match a full period and not the remaining half.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
    localparam int A_W = 10;
    localparam int B_W = 8;

    typedef enum logic [1:0] {
        SEL_A_HI = 2'd0,
        SEL_A_LO = 2'd1,
        SEL_B    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // control write image, bit 0 at the bottom
    typedef struct packed {
        logic clr_b;   // bit 5
        logic clr_a;   // bit 4
        logic en_b;    // bit 3
        logic en_a;    // bit 2
        logic load_b;  // bit 1
        logic load_a;  // bit 0
    } ctrl_bits_t;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } start_vals_t;

    function automatic logic went_high(input logic old_v, input logic new_v);
        return !old_v && new_v;
    endfunction

    function automatic int min_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction
endpackage

// File: rtl/twin_timer_prescale.sv
module twin_timer_prescale
    import twin_timer_pkg::*;
#(
    parameter int PRESCALE = 144,
    parameter int B_SUBDIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick_a,
    output logic tick_b
);
    localparam int PW = min_one($clog2(PRESCALE));
    localparam int SW = min_one($clog2(B_SUBDIV));
    localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
    localparam logic [SW-1:0] S_LAST = SW'(B_SUBDIV - 1);

    logic [PW-1:0] pcnt;
    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (pcnt == P_LAST) begin
            pcnt <= '0;
            scnt <= (scnt == S_LAST) ? '0 : scnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign tick_a = (pcnt == P_LAST);
    assign tick_b = tick_a && (scnt == S_LAST);

    generate
        if (PRESCALE > 1) begin : g_gap
            // R1: ticks of the fast timer are spaced by the prescaler
            p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
                tick_a |=> !tick_a);
        end
    endgenerate
endmodule

// File: rtl/twin_timer_count.sv
module twin_timer_count #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] start_val,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (restart) begin
                cnt <= start_val;
            end else if (run && tick) begin
                if (cnt == TOP) begin
                    cnt <= start_val;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);
    p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ovf);
    p_restart_value_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == $past(start_val)));
endmodule

// File: rtl/twin_timer_regs.sv
module twin_timer_regs
    import twin_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output start_vals_t starts,
    output logic [1:0]  run,
    output logic [1:0]  en,
    output logic [1:0]  restart,
    output logic [1:0]  clr
);
    ctrl_bits_t wbits;
    logic       ctrl_wr;
    logic [7:0] a_hi;
    logic [1:0] a_lo;
    logic [7:0] b_val;

    assign wbits   = ctrl_bits_t'(wr_data[5:0]);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_hi  <= '0;
            a_lo  <= '0;
            b_val <= '0;
            run   <= '0;
            en    <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_A_HI: a_hi  <= wr_data;
                SEL_A_LO: a_lo  <= wr_data[1:0];
                SEL_B:    b_val <= wr_data;
                SEL_CTRL: begin
                    run <= {wbits.load_b, wbits.load_a};
                    en  <= {wbits.en_b, wbits.en_a};
                end
                default: ;
            endcase
        end
    end

    assign starts.a   = {a_hi, a_lo};
    assign starts.b   = b_val;
    assign restart[0] = ctrl_wr && went_high(run[0], wbits.load_a);
    assign restart[1] = ctrl_wr && went_high(run[1], wbits.load_b);
    assign clr[0]     = ctrl_wr && wbits.clr_a;
    assign clr[1]     = ctrl_wr && wbits.clr_b;

    p_run_kept_r5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(run));
    p_restart_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (restart != 2'b00) |-> ((restart & run) == 2'b00));
endmodule

// File: rtl/twin_timer_flags.sv
module twin_timer_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ovf,
    input  logic [1:0] en,
    input  logic [1:0] clr,
    output logic [1:0] flag
);
    generate
        for (genvar i = 0; i < 2; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)                  flag[i] <= 1'b0;
                else if (ovf[i] && en[i]) flag[i] <= 1'b1;
                else if (clr[i])          flag[i] <= 1'b0;
            end

            p_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
                $rose(flag[i]) |-> $past(ovf[i] && en[i]));
            p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
                (ovf[i] && en[i]) |=> flag[i]);
            p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !(ovf[i] && en[i])) |=> !flag[i]);
        end
    endgenerate
endmodule

// File: rtl/twin_timer.sv
module twin_timer
    import twin_timer_pkg::*;
#(
    parameter int PRESCALE = 144,
    parameter int B_SUBDIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       ovf_a,
    output logic       ovf_b,
    output logic       flag_a,
    output logic       flag_b
);
    logic        tick_a, tick_b;
    start_vals_t starts;
    logic [1:0]  run, en, restart, clr, flag;

    twin_timer_prescale #(.PRESCALE(PRESCALE), .B_SUBDIV(B_SUBDIV)) u_pre (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b)
    );

    twin_timer_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .starts(starts), .run(run), .en(en), .restart(restart), .clr(clr)
    );

    twin_timer_count #(.W(A_W)) u_cnt_a (
        .clk(clk), .rst(rst), .tick(tick_a), .run(run[0]),
        .restart(restart[0]), .start_val(starts.a), .ovf(ovf_a)
    );

    twin_timer_count #(.W(B_W)) u_cnt_b (
        .clk(clk), .rst(rst), .tick(tick_b), .run(run[1]),
        .restart(restart[1]), .start_val(starts.b), .ovf(ovf_b)
    );

    twin_timer_flags u_flags (
        .clk(clk), .rst(rst), .ovf({ovf_b, ovf_a}), .en(en), .clr(clr), .flag(flag)
    );

    assign flag_a = flag[0];
    assign flag_b = flag[1];

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !ovf_a && !ovf_b && !flag_a && !flag_b);
endmodule

// File: tb/tb_twin_timer.sv
module tb_twin_timer;
    localparam int PRE = 3;
    localparam int SUB = 2;
    localparam int LA = 1, LB = 2, EA = 4, EB = 8, CA = 16, CB = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ovf_a, ovf_b, flag_a, flag_b;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    twin_timer #(.PRESCALE(PRE), .B_SUBDIV(SUB)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovf_a(ovf_a), .ovf_b(ovf_b), .flag_a(flag_a), .flag_b(flag_b)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ovf(input bit which_b, output int t);
        int n = 0;
        t = -1;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if ((which_b ? ovf_b : ovf_a) == 1'b1) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) chk("timeout waiting for strobe", 0, 1);
    endtask

    task automatic count_strobes(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ovf_a || ovf_b) n++;
        end
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        chk("R9 ovf_a after reset", ovf_a, 0);
        chk("R9 flags after reset", {flag_b, flag_a}, 0);
        count_strobes(60, n);
        chk("R9 no strobe before load", n, 0);
    endtask

    task automatic t_period_a();
        int t0, t1, t2, t3;
        wr(0, 255); wr(1, 0);            // NA = 1020
        wr(3, LA);
        wait_ovf(0, t0); wait_ovf(0, t1);
        chk("R1 period NA=1020", t1 - t0, PRE * 4);
        @(negedge clk);
        chk("R3 strobe one cycle", ovf_a, 0);
        wait_ovf(0, t2);
        chk("R3 steady period", t2 - t1, PRE * 4);
        wr(1, 3);                        // NA = 1023
        wait_ovf(0, t0); wait_ovf(0, t1); wait_ovf(0, t2);
        chk("R1 period NA=1023", t2 - t1, PRE);
        wr(0, 0); wr(1, 0);              // NA = 0
        wait_ovf(0, t0); wait_ovf(0, t1); wait_ovf(0, t3);
        chk("R1 period NA=0", t3 - t1, PRE * 1024);
        wr(3, 0);
    endtask

    task automatic t_period_b();
        int t0, t1, t2;
        wr(2, 250);
        wr(3, LB);
        wait_ovf(1, t0); wait_ovf(1, t1);
        chk("R2 period NB=250", t1 - t0, PRE * SUB * 6);
        wr(2, 0);
        wait_ovf(1, t0); wait_ovf(1, t1); wait_ovf(1, t2);
        chk("R2 period NB=0", t2 - t1, PRE * SUB * 256);
        wr(3, 0);
    endtask

    task automatic t_restart();
        int s, w, e, n;
        wr(0, 250); wr(1, 0);            // NA = 1000, 24 ticks
        wr(3, LA);
        wait_ovf(0, s);
        repeat (36) @(negedge clk);
        wr(3, 0);
        count_strobes(80, n);
        chk("R4 stopped timer silent", n, 0);
        wr(3, LA);
        w = cyc;
        wait_ovf(0, e);
        chk_rng("R4 restart full period", e - w, PRE * 23 + 1, PRE * 24);
    endtask

    task automatic t_rewrite();
        int s0, s1;
        wait_ovf(0, s0);
        repeat (15) @(negedge clk);
        wr(3, LA | EA);
        repeat (5) @(negedge clk);
        wr(3, LA | CA);
        wr(3, LA);
        wait_ovf(0, s1);
        chk("R5 control rewrite keeps timing", s1 - s0, PRE * 24);
    endtask

    task automatic t_split();
        int s0, s1, s2, s3, s4;
        wait_ovf(0, s0);
        repeat (5) @(negedge clk);
        wr(1, 3);                        // NA = 1003
        wait_ovf(0, s1);
        chk("R6 current period unchanged", s1 - s0, PRE * 24);
        wait_ovf(0, s2);
        chk("R6 low half used at reload", s2 - s1, PRE * 21);
        repeat (5) @(negedge clk);
        wr(0, 254);                      // NA = 1019
        wr(1, 0);                        // NA = 1016
        wait_ovf(0, s3);
        chk("R6 both halves wait for reload", s3 - s2, PRE * 21);
        wait_ovf(0, s4);
        chk("R6 high then low applied", s4 - s3, PRE * 8);
        wr(3, 0);
    endtask

    task automatic t_flags_a();
        int s;
        wr(0, 255); wr(1, 0);            // NA = 1020
        wr(3, LA);
        wait_ovf(0, s);
        @(negedge clk);
        chk("R7 flag_a stays low without enable", flag_a, 0);
        wr(3, LA | EA);
        wait_ovf(0, s);
        chk("R7 flag_a low on strobe cycle", flag_a, 0);
        @(negedge clk);
        chk("R7 flag_a set after enabled strobe", flag_a, 1);
        wr(3, LA | EA | CA);
        chk("R8 flag_a cleared by reset bit", flag_a, 0);
        wait_ovf(0, s);
        @(negedge clk);
        chk("R8 reset bit not stored", flag_a, 1);
        wr(3, LA | CA);
        wait_ovf(0, s);
        @(negedge clk);
        chk("R7 flag_a not set after disable", flag_a, 0);
        wr(3, 0);
    endtask

    task automatic t_flags_b();
        int s;
        wr(2, 255);                      // NB = 255
        wr(3, LB | EB);
        wait_ovf(1, s);
        @(negedge clk);
        chk("R7 flag_b set after enabled strobe", flag_b, 1);
        chk("R7 flag_a untouched by timer B", flag_a, 0);
        wr(3, LB | EB | CB);
        chk("R8 flag_b cleared by reset bit", flag_b, 0);
        wait_ovf(1, s);
        @(negedge clk);
        chk("R8 flag_b sets again", flag_b, 1);
        wr(3, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_period_a();
        t_period_b();
        t_restart();
        t_rewrite();
        t_split();
        t_flags_a();
        t_flags_b();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule